// File: doc/BRIEF.md
# Dual-Policy Flag Register Bank

This block holds a bank of per-source flag bits that software writes through a plain register bus strobe. A stored policy bit decides what a write means. In set-only mode a 1 in the written word sets the matching flag and a 0 leaves it alone. Software can then set one flag without touching any other flag. In read/write mode the written word replaces the whole bank, so every position written with 0 is cleared.

Independent of software, a hardware clear vector drops individual flags, for instance when the consumer behind a flag has finished its job. The flags and the policy bit are always visible on parallel outputs. In read/write mode, a read-modify-write by software can restore a flag that hardware cleared between the read and the write. The block keeps this behaviour and does not guard against it.

Top module: `flag_policy_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `flags` is 0.
- R2: While reset is asserted, and after it is released, `mode_rw` is 0, which selects set-only mode (1 selects read/write mode).
- R3: In set-only mode, a write with bit i of `wr_data` equal to 1 makes `flags[i]` 1 in the cycle after the write edge.
- R4: In set-only mode, a flag whose bit of `wr_data` is 0 keeps its value across the write, provided no hardware clear targets it.
- R5: In read/write mode, `flags` equals `wr_data` in the cycle after the write edge. A stale word written back therefore re-sets a flag that hardware cleared after software read it.
- R6: A 1 in bit i of `hw_clr` makes `flags[i]` 0 after the edge, unless the same edge carries a software write of 1 to bit i.
- R7: When a software write of 1 and a hardware clear hit the same bit at the same edge, the flag ends up 1, in either mode.
- R8: `mode_we` loads `mode_sel` into `mode_rw` at the edge. A data write at that same edge is applied under the policy that was in force before the change.
- R9: With no write and no hardware clear, `flags` holds its value. The outputs come straight from registers and can be read in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the flag word |
| wr_data | input | N | Written flag word |
| hw_clr | input | N | Per-bit hardware clear requests |
| mode_we | input | 1 | Write strobe for the policy bit |
| mode_sel | input | 1 | New policy: 0 set-only, 1 read/write |
| flags | output | N | Current flag bits |
| mode_rw | output | 1 | Current policy bit |

## Verification
The hardest situation to bring about is a software write of 1 that collides with a hardware clear on the same bit at the same edge, in each policy. The other hard case is a read-modify-write hazard, where hardware clears a flag after software has read the bank and before software writes the stale word back. The stimulus first reads `flags` and then pulses `hw_clr` on one of the set bits. It then writes the old word back in read/write mode and checks that the flag returns. A third stimulus switches the policy at the same edge as a data write, which shows which policy that write was applied under.

// File: rtl/flag_policy_pkg.sv
package flag_policy_pkg;

  typedef enum logic {
    POL_SET_ONLY = 1'b0,
    POL_RW       = 1'b1
  } wr_policy_e;

  // Per-bit next state: software set beats any clear.
  function automatic logic flag_next(input logic q, input logic sw_set,
                                     input logic sw_clr, input logic hw_clr);
    logic n;
    if (sw_set)               n = 1'b1;
    else if (sw_clr || hw_clr) n = 1'b0;
    else                      n = q;
    return n;
  endfunction

endpackage

// File: rtl/flag_policy_reg.sv
module flag_policy_reg
  import flag_policy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       mode_sel,
  output wr_policy_e policy
);

  wr_policy_e policy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       policy_q <= POL_SET_ONLY;
    else if (mode_we) policy_q <= wr_policy_e'(mode_sel);
  end

  assign policy = policy_q;

  p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (policy == wr_policy_e'($past(mode_sel))));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(policy));

endmodule

// File: rtl/flag_write_decode.sv
module flag_write_decode
  import flag_policy_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  wr_policy_e   policy,
  output logic [N-1:0] sw_set,
  output logic [N-1:0] sw_clr
);

  logic rw_mode;
  assign rw_mode = (policy == POL_RW);

  // Ones always set; zeros clear only under the read/write policy.
  assign sw_set = {N{wr_en}} & wr_data;
  assign sw_clr = {N{wr_en & rw_mode}} & ~wr_data;

endmodule

// File: rtl/flag_bit_bank.sv
module flag_bit_bank
  import flag_policy_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= flag_next(bit_q, sw_set[i], sw_clr[i], hw_clr[i]);
    end
    assign flags[i] = bit_q;
  end

  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((flags & $past(sw_set)) == $past(sw_set)));

  p_clr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_clr | sw_clr) != '0) |=>
      ((flags & $past((hw_clr | sw_clr) & ~sw_set)) == '0));

  p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) &
                ~$past(sw_set | sw_clr | hw_clr)) == '0));

endmodule

// File: rtl/flag_policy_bank.sv
module flag_policy_bank
  import flag_policy_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] hw_clr,
  input  logic         mode_we,
  input  logic         mode_sel,
  output logic [N-1:0] flags,
  output logic         mode_rw
);

  wr_policy_e   policy;
  logic [N-1:0] sw_set;
  logic [N-1:0] sw_clr;

  flag_policy_reg u_policy (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (mode_we),
    .mode_sel (mode_sel),
    .policy   (policy)
  );

  flag_write_decode #(.N(N)) u_decode (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .policy  (policy),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr)
  );

  flag_bit_bank #(.N(N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_set (sw_set),
    .sw_clr (sw_clr),
    .hw_clr (hw_clr),
    .flags  (flags)
  );

  assign mode_rw = (policy == POL_RW);

  p_rw_replace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_rw) |=> (flags == $past(wr_data)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags & $past(wr_data & hw_clr)) == $past(wr_data & hw_clr)));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (hw_clr == '0)) |=> $stable(flags));

  p_first_cycle_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && !mode_rw));

endmodule

// File: tb/flag_policy_bank_bench.sv
`timescale 1ns/1ps
module flag_policy_bank_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] hw_clr = '0;
  logic         mode_we = 1'b0;
  logic         mode_sel = 1'b0;
  logic [N-1:0] flags;
  logic         mode_rw;

  always #2 clk = ~clk;

  flag_policy_bank #(.N(N)) u_flag_policy_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_clr(hw_clr), .mode_we(mode_we), .mode_sel(mode_sel),
    .flags(flags), .mode_rw(mode_rw)
  );

  typedef struct {
    logic [N-1:0] exp_flags;
    logic         exp_mode;
    string        tag;
  } item_t;

  item_t        sb[$];
  int           checks = 0;
  int           failures = 0;
  logic [N-1:0] m_flags = '0;
  logic         m_mode = 1'b0;
  logic         done = 1'b0;

  task automatic check_now(input string tag, input logic [N-1:0] ef, input logic em);
    checks++;
    if (flags !== ef || mode_rw !== em) begin
      failures++;
      $display("FAIL %s flags=%h mode=%b expected flags=%h mode=%b",
               tag, flags, mode_rw, ef, em);
    end
  endtask

  // Reference model written as per-bit rules from the requirements.
  task automatic step(input string tag, input logic we, input logic [N-1:0] d,
                      input logic [N-1:0] clr, input logic mwe, input logic msel);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_data = d; hw_clr = clr; mode_we = mwe; mode_sel = msel;
    for (int i = 0; i < N; i++) begin
      if (we && d[i])                 m_flags[i] = 1'b1;   // R3/R7
      else if (we && m_mode && !d[i]) m_flags[i] = 1'b0;   // R5
      else if (clr[i])                m_flags[i] = 1'b0;   // R6
    end
    if (mwe) m_mode = msel;                                // R8
    @(posedge clk);
    #1;
    wr_en = 1'b0; hw_clr = '0; mode_we = 1'b0;
    it.exp_flags = m_flags; it.exp_mode = m_mode; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check_now(it.tag, it.exp_flags, it.exp_mode);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_now("R1 R2 during reset", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_flags = '0; m_mode = 1'b0;
    @(negedge clk);
    check_now("R1 R2 after release", '0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [N-1:0] snap;
    do_reset();
    step("R3 set-only sets ones",          1, 16'h0005, 16'h0000, 0, 0);
    step("R3 R4 set-only keeps others",    1, 16'h0100, 16'h0000, 0, 0);
    step("R4 set-only zero write no-op",   1, 16'h0000, 16'h0000, 0, 0);
    step("R6 hw clear idle bus",           0, 16'h0000, 16'h0001, 0, 0);
    step("R6 hw clear with zero write",    1, 16'h0000, 16'h0004, 0, 0);
    step("R7 set beats clear set-only",    1, 16'h0010, 16'h0010, 0, 0);
    step("R8 switch uses old policy",      1, 16'h0000, 16'h0000, 1, 1);
    step("R5 rw replaces word",            1, 16'h00F0, 16'h0000, 0, 0);
    snap = flags;
    step("R6 hw clear between read/write", 0, 16'h0000, 16'h0010, 0, 0);
    step("R5 stale write-back re-sets",    1, snap,     16'h0000, 0, 0);
    step("R7 set beats clear rw",          1, 16'h0001, 16'h0001, 0, 0);
    step("R5 R6 rw with clears",           1, 16'h8000, 16'h0F00, 0, 0);
    step("R9 idle hold",                   0, 16'h0000, 16'h0000, 0, 0);
    step("R9 idle hold again",             0, 16'hFFFF, 16'h0000, 0, 0);
    step("R8 mode write alone",            0, 16'h0000, 16'h0000, 1, 1);
    step("R8 switch back under rw",        1, 16'h0003, 16'h0000, 1, 0);
    step("R4 set-only after return",       1, 16'h0000, 16'h0000, 0, 0);
    step("R3 set all",                     1, 16'hFFFF, 16'h0000, 0, 0);
    step("R6 R7 mixed",                    1, 16'h0A0A, 16'hFF00, 0, 0);
    repeat (3) @(negedge clk);
    do_reset();
    step("R3 after second reset",          1, 16'h4000, 16'h0000, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule